// File: doc/BRIEF.md
# Register rename unit with rename buffer file

This block sits at the dispatch point of an out-of-order core and renames one instruction per cycle. Each dispatched instruction names a destination and two source architectural registers. The block takes a free rename buffer for the destination and records the new mapping in a per-register map. For each source it returns either a ready operand or the index (tag) of the rename buffer that will later hold the value. The operand comes from the rename buffer when the source is mapped and from the architectural file when it is not. Results that come back from execution are written into the buffer named by their tag.

Instructions retire in program order. At retirement the buffer's value is copied into the architectural register, and the buffer returns to the free pool. A flush discards every instruction that has not retired. Each buffer runs a three-state lifecycle with named states. FREE is the state after reset. It goes to PEND on the transition *allocate*, taken when the buffer is chosen at dispatch. PEND goes to DONE on the transition *fill*, taken when a writeback arrives for it. DONE goes back to FREE on *retire*, taken at completion. A flush sends every PEND or DONE buffer to FREE on the transition *cancel*.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset every buffer is FREE and no register is mapped. disp_ready is 1, disp_tag is 0, both sources report ready with value 0, and cmp_ready is 0.
- R2: An accepted dispatch takes the lowest-numbered FREE buffer, whose index is shown on disp_tag. That buffer moves to PEND, and the map entry of disp_rd is set to point at it.
- R3: A source whose register has no mapping is reported ready, with the value from the architectural file.
- R4: A source mapped to a PEND buffer is reported not ready, and its tag output carries the mapped buffer index.
- R5: A source mapped to a DONE buffer is reported ready with the buffer's value, even when the architectural register holds a different value.
- R6: A writeback with wb_valid moves the addressed PEND buffer to DONE and stores wb_data in it. A writeback to a buffer that is not PEND has no effect.
- R7: cmp_ready is 1 exactly when the oldest unretired instruction's buffer is DONE. When cmp_valid is also 1, the buffer value is written to that instruction's destination register, the buffer becomes FREE, and retirement advances to the next-oldest instruction in dispatch order. cmp_valid while cmp_ready is 0 has no effect.
- R8: Retirement clears the map entry of the destination only if that entry still points at the retiring buffer. A younger mapping of the same register survives.
- R9: Source lookups and all outputs reflect the state at the start of the cycle. An instruction naming its own destination as a source sees the older mapping. A writeback or retirement in the same cycle becomes visible only in the next cycle.
- R10: When no buffer is FREE, disp_ready is 0, and disp_valid has no effect.
- R11: While flush is 1, disp_ready and cmp_ready are 0, and dispatch, writeback and retirement are ignored. After the flush edge every buffer is FREE and every mapping is cleared, while the architectural file keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Instruction offered for renaming |
| disp_ready | output | 1 | A buffer is free and no flush is in progress |
| disp_rd | input | 3 | Destination architectural register |
| disp_rs1 | input | 3 | First source architectural register |
| disp_rs2 | input | 3 | Second source architectural register |
| disp_tag | output | 2 | Buffer allocated to the destination |
| src1_ready | output | 1 | First source value is available |
| src1_data | output | 16 | First source value |
| src1_tag | output | 2 | Buffer the first source waits on |
| src2_ready | output | 1 | Second source value is available |
| src2_data | output | 16 | Second source value |
| src2_tag | output | 2 | Buffer the second source waits on |
| wb_valid | input | 1 | Result writeback strobe |
| wb_tag | input | 2 | Buffer receiving the result |
| wb_data | input | 16 | Result value |
| cmp_valid | input | 1 | Retire the oldest instruction |
| cmp_ready | output | 1 | The oldest instruction's result is present |
| flush | input | 1 | Cancel all unretired instructions |

## Verification
The hardest case is a retirement that meets a younger rename of the same register. The older buffer must retire while the map already points at a newer PEND buffer, and the map must keep pointing at the newer one. The directed part of the bench builds this case on purpose: it renames register 1 twice and then retires the first instruction. A randomized phase follows that draws registers from a narrow range, so the case recurs many times. That phase also mixes buffer-full stalls, writebacks to stale tags, ignored retire requests and flushes. Every output is compared each cycle against a behavioural model.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [1:0] {
        RN_FREE = 2'd0,
        RN_PEND = 2'd1,
        RN_DONE = 2'd2
    } rn_state_e;
endpackage

// File: rtl/rn_entry_file.sv
module rn_entry_file
    import rn_pkg::*;
#(
    parameter int NUM_REN = 4,
    parameter int DATA_W  = 16,
    parameter int AREG_W  = 3,
    localparam int TAG_W  = $clog2(NUM_REN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [AREG_W-1:0] alloc_rd,
    input  logic              wb_en,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              free_en,
    input  logic [TAG_W-1:0]  free_tag,
    output logic              free_any,
    output logic [TAG_W-1:0]  free_idx,
    input  logic [TAG_W-1:0]  look_tag1,
    input  logic [TAG_W-1:0]  look_tag2,
    output rn_state_e         look_state1,
    output rn_state_e         look_state2,
    output logic [DATA_W-1:0] look_data1,
    output logic [DATA_W-1:0] look_data2,
    input  logic [TAG_W-1:0]  head_tag,
    output rn_state_e         head_state,
    output logic [DATA_W-1:0] head_data,
    output logic [AREG_W-1:0] head_rd
);
    rn_state_e         st_all   [NUM_REN];
    logic [DATA_W-1:0] data_all [NUM_REN];
    logic [AREG_W-1:0] rd_all   [NUM_REN];

    for (genvar i = 0; i < NUM_REN; i++) begin : g_ent
        rn_state_e         st_q, st_d;
        logic [DATA_W-1:0] data_q;
        logic [AREG_W-1:0] rd_q;
        logic              hit_alloc, hit_wb, hit_free;

        assign hit_alloc = alloc_en && (alloc_tag == TAG_W'(i));
        assign hit_wb    = wb_en    && (wb_tag    == TAG_W'(i));
        assign hit_free  = free_en  && (free_tag  == TAG_W'(i));

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                RN_FREE: if (hit_alloc) st_d = RN_PEND;
                RN_PEND: if (hit_wb)    st_d = RN_DONE;
                RN_DONE: if (hit_free)  st_d = RN_FREE;
                default: st_d = RN_FREE;
            endcase
            if (flush) st_d = RN_FREE;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= RN_FREE;
            else        st_q <= st_d;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q <= '0;
                rd_q   <= '0;
            end else begin
                if (hit_wb && st_q == RN_PEND && !flush) data_q <= wb_data;
                if (hit_alloc && st_q == RN_FREE && !flush) rd_q <= alloc_rd;
            end
        end

        assign st_all[i]   = st_q;
        assign data_all[i] = data_q;
        assign rd_all[i]   = rd_q;
    end

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = NUM_REN - 1; i >= 0; i--) begin
            if (st_all[i] == RN_FREE) begin
                free_any = 1'b1;
                free_idx = TAG_W'(i);
            end
        end
    end

    assign look_state1 = st_all[look_tag1];
    assign look_state2 = st_all[look_tag2];
    assign look_data1  = data_all[look_tag1];
    assign look_data2  = data_all[look_tag2];
    assign head_state  = st_all[head_tag];
    assign head_data   = data_all[head_tag];
    assign head_rd     = rd_all[head_tag];
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NUM_AREG = 8,
    parameter int NUM_REN  = 4,
    localparam int AREG_W  = $clog2(NUM_AREG),
    localparam int TAG_W   = $clog2(NUM_REN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              set_en,
    input  logic [AREG_W-1:0] set_rd,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              clr_en,
    input  logic [AREG_W-1:0] clr_rd,
    input  logic [TAG_W-1:0]  clr_tag,
    input  logic [AREG_W-1:0] rs1,
    input  logic [AREG_W-1:0] rs2,
    output logic              hit1,
    output logic [TAG_W-1:0]  tag1,
    output logic              hit2,
    output logic [TAG_W-1:0]  tag2
);
    logic             map_v [NUM_AREG];
    logic [TAG_W-1:0] map_t [NUM_AREG];

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int r = 0; r < NUM_AREG; r++) begin
                map_v[r] <= 1'b0;
                map_t[r] <= '0;
            end
        end else begin
            if (clr_en && map_v[clr_rd] && map_t[clr_rd] == clr_tag)
                map_v[clr_rd] <= 1'b0;
            if (set_en) begin
                map_v[set_rd] <= 1'b1;
                map_t[set_rd] <= set_tag;
            end
        end
    end

    assign hit1 = map_v[rs1];
    assign tag1 = map_t[rs1];
    assign hit2 = map_v[rs2];
    assign tag2 = map_t[rs2];
endmodule

// File: rtl/rn_order_fifo.sv
module rn_order_fifo #(
    parameter int NUM_REN = 4,
    localparam int TAG_W  = $clog2(NUM_REN),
    localparam int CNT_W  = $clog2(NUM_REN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop,
    output logic [TAG_W-1:0] head_tag,
    output logic             nonempty
);
    logic [TAG_W-1:0] slot [NUM_REN];
    logic [TAG_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(NUM_REN - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slot[wr_ptr] <= push_tag;
                wr_ptr       <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_tag = slot[rd_ptr];
    assign nonempty = (count != '0);
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit
    import rn_pkg::*;
#(
    parameter int NUM_AREG = 8,
    parameter int NUM_REN  = 4,
    parameter int DATA_W   = 16,
    localparam int AREG_W  = $clog2(NUM_AREG),
    localparam int TAG_W   = $clog2(NUM_REN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    output logic              disp_ready,
    input  logic [AREG_W-1:0] disp_rd,
    input  logic [AREG_W-1:0] disp_rs1,
    input  logic [AREG_W-1:0] disp_rs2,
    output logic [TAG_W-1:0]  disp_tag,
    output logic              src1_ready,
    output logic [DATA_W-1:0] src1_data,
    output logic [TAG_W-1:0]  src1_tag,
    output logic              src2_ready,
    output logic [DATA_W-1:0] src2_data,
    output logic [TAG_W-1:0]  src2_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              cmp_valid,
    output logic              cmp_ready,
    input  logic              flush
);
    logic              free_any, disp_fire, cmp_fire, fifo_nonempty;
    logic [TAG_W-1:0]  free_idx, head_tag, map_tag1, map_tag2;
    logic              map_hit1, map_hit2;
    rn_state_e         look_state1, look_state2, head_state;
    logic [DATA_W-1:0] look_data1, look_data2, head_data;
    logic [AREG_W-1:0] head_rd;
    logic [DATA_W-1:0] arch_q [NUM_AREG];

    assign disp_ready = free_any && !flush;
    assign disp_fire  = disp_valid && disp_ready;
    assign disp_tag   = free_idx;
    assign cmp_ready  = fifo_nonempty && (head_state == RN_DONE) && !flush;
    assign cmp_fire   = cmp_valid && cmp_ready;

    rn_entry_file #(.NUM_REN(NUM_REN), .DATA_W(DATA_W), .AREG_W(AREG_W)) u_ent (
        .clk, .rst_n, .flush,
        .alloc_en(disp_fire), .alloc_tag(free_idx), .alloc_rd(disp_rd),
        .wb_en(wb_valid && !flush), .wb_tag, .wb_data,
        .free_en(cmp_fire), .free_tag(head_tag),
        .free_any, .free_idx,
        .look_tag1(map_tag1), .look_tag2(map_tag2),
        .look_state1, .look_state2, .look_data1, .look_data2,
        .head_tag, .head_state, .head_data, .head_rd
    );

    rn_map_table #(.NUM_AREG(NUM_AREG), .NUM_REN(NUM_REN)) u_map (
        .clk, .rst_n, .flush,
        .set_en(disp_fire), .set_rd(disp_rd), .set_tag(free_idx),
        .clr_en(cmp_fire), .clr_rd(head_rd), .clr_tag(head_tag),
        .rs1(disp_rs1), .rs2(disp_rs2),
        .hit1(map_hit1), .tag1(map_tag1), .hit2(map_hit2), .tag2(map_tag2)
    );

    rn_order_fifo #(.NUM_REN(NUM_REN)) u_ord (
        .clk, .rst_n, .flush,
        .push(disp_fire), .push_tag(free_idx), .pop(cmp_fire),
        .head_tag, .nonempty(fifo_nonempty)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_AREG; r++) arch_q[r] <= '0;
        end else if (cmp_fire) begin
            arch_q[head_rd] <= head_data;
        end
    end

    always_comb begin
        src1_tag   = map_tag1;
        src1_ready = !map_hit1 || (look_state1 == RN_DONE);
        src1_data  = map_hit1 ? look_data1 : arch_q[disp_rs1];
        src2_tag   = map_tag2;
        src2_ready = !map_hit2 || (look_state2 == RN_DONE);
        src2_data  = map_hit2 ? look_data2 : arch_q[disp_rs2];
    end
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter int NUM_REN = 4,
    localparam int CNT_W  = $clog2(NUM_REN + 1)
) (
    input logic clk,
    input logic rst_n,
    input logic disp_valid,
    input logic disp_ready,
    input logic src1_ready,
    input logic src2_ready,
    input logic cmp_valid,
    input logic cmp_ready,
    input logic flush
);
    logic [CNT_W-1:0] inflight;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) inflight <= '0;
        else inflight <= inflight + CNT_W'(disp_valid && disp_ready)
                                  - CNT_W'(cmp_valid && cmp_ready);
    end

    // R10
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == CNT_W'(NUM_REN)) |-> !disp_ready);

    // R2
    free_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight < CNT_W'(NUM_REN) && !flush) |-> disp_ready);

    // R11
    flush_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (flush || (disp_ready && !cmp_ready && src1_ready && src2_ready)));

    // R7
    cmp_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_ready |-> (inflight != '0));

    // R4
    src_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!src1_ready || !src2_ready) |-> (inflight != '0));
endmodule

bind rn_rename_unit rn_rename_chk #(.NUM_REN(NUM_REN)) u_chk (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .src1_ready(src1_ready), .src2_ready(src2_ready),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .flush(flush)
);

// File: tb/rn_rename_unit_tb.sv
module rn_rename_unit_tb;
    localparam int NA = 8, NR = 4, DW = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic disp_valid, disp_ready, src1_ready, src2_ready, wb_valid, cmp_valid, cmp_ready, flush;
    logic [2:0] disp_rd, disp_rs1, disp_rs2;
    logic [1:0] disp_tag, src1_tag, src2_tag, wb_tag;
    logic [DW-1:0] src1_data, src2_data, wb_data;

    always #2 clk = ~clk;

    rn_rename_unit u_dut (
        .clk, .rst_n, .disp_valid, .disp_ready, .disp_rd, .disp_rs1, .disp_rs2, .disp_tag,
        .src1_ready, .src1_data, .src1_tag, .src2_ready, .src2_data, .src2_tag,
        .wb_valid, .wb_tag, .wb_data, .cmp_valid, .cmp_ready, .flush
    );

    int compared = 0, mismatched = 0;
    bit done = 0;

    // behavioural model: 0 free, 1 waiting for result, 2 result present
    int          mst [NR];
    logic [DW-1:0] mdat [NR];
    int          mrd [NR];
    bit          mv  [NA];
    int          mt  [NA];
    logic [DW-1:0] marc [NA];
    int          q [$];

    task automatic chk(string req, string lbl, string what, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s (%s) %s actual=%0h expected=%0h", req, lbl, what, act, exp);
        end
    endtask

    task automatic chk_src(string lbl, string nm, int rs, logic rdy, logic [DW-1:0] d, logic [1:0] t);
        if (mv[rs]) begin
            if (mst[mt[rs]] == 2) begin
                chk("R5", lbl, {nm, " ready"}, rdy, 1);
                chk("R5", lbl, {nm, " data"}, d, mdat[mt[rs]]);
            end else begin
                chk("R4", lbl, {nm, " ready"}, rdy, 0);
                chk("R4", lbl, {nm, " tag"}, t, mt[rs]);
            end
        end else begin
            chk("R3", lbl, {nm, " ready"}, rdy, 1);
            chk("R3", lbl, {nm, " data"}, d, marc[rs]);
        end
    endtask

    function automatic int low_free();
        for (int i = 0; i < NR; i++) if (mst[i] == 0) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NR; i++) begin mst[i] = 0; mdat[i] = 0; mrd[i] = 0; end
        for (int r = 0; r < NA; r++) begin mv[r] = 0; mt[r] = 0; marc[r] = 0; end
        q.delete();
    endtask

    task automatic step(string lbl, bit dv, int rd, int rs1, int rs2,
                        bit wv, int wt, int wd, bit cv, bit fl);
        int lf;
        bit exp_cr;
        disp_valid = dv; disp_rd = 3'(rd); disp_rs1 = 3'(rs1); disp_rs2 = 3'(rs2);
        wb_valid = wv; wb_tag = 2'(wt); wb_data = DW'(wd); cmp_valid = cv; flush = fl;
        #1;
        lf = low_free();
        chk("R10", lbl, "disp_ready", disp_ready, (!fl && lf >= 0));
        if (!fl && lf >= 0) chk("R2", lbl, "disp_tag", disp_tag, lf);
        chk_src(lbl, "src1", rs1, src1_ready, src1_data, src1_tag);
        chk_src(lbl, "src2", rs2, src2_ready, src2_data, src2_tag);
        exp_cr = !fl && q.size() > 0 && mst[q[0]] == 2;
        chk("R7", lbl, "cmp_ready", cmp_ready, exp_cr);
        @(posedge clk);
        if (fl) begin
            for (int i = 0; i < NR; i++) mst[i] = 0;
            for (int r = 0; r < NA; r++) mv[r] = 0;
            q.delete();
        end else begin
            if (wv && mst[wt] == 1) begin mst[wt] = 2; mdat[wt] = DW'(wd); end
            if (cv && exp_cr) begin
                int h = q.pop_front();
                marc[mrd[h]] = mdat[h];
                mst[h] = 0;
                if (mv[mrd[h]] && mt[mrd[h]] == h) mv[mrd[h]] = 0;
            end
            if (dv && lf >= 0) begin
                mst[lf] = 1; mrd[lf] = rd; mv[rd] = 1; mt[rd] = lf; q.push_back(lf);
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(string lbl, int rs1, int rs2);
        step(lbl, 0, 0, rs1, rs2, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 0; disp_valid = 0; disp_rd = 0; disp_rs1 = 0; disp_rs2 = 0;
        wb_valid = 0; wb_tag = 0; wb_data = 0; cmp_valid = 0; flush = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        idle("R1", 3, 7);
        // R9: reads own destination, sees older (unmapped) value
        step("R9", 1, 1, 1, 2, 0, 0, 0, 0, 0);
        idle("R4", 1, 2);
        // R9: same-cycle writeback not visible yet
        step("R9", 0, 0, 1, 1, 1, 0, 16'h1111, 0, 0);
        // R6: result now present
        idle("R6", 1, 2);
        // R2: second rename of register 1
        step("R2", 1, 1, 1, 5, 0, 0, 0, 0, 0);
        // R6: writeback to stale tag ignored
        step("R6", 0, 0, 1, 1, 1, 0, 16'hdead, 0, 0);
        idle("R6", 1, 1);
        // R7: ignored retire while head not ready is covered later; retire head now
        step("R7", 0, 0, 1, 1, 0, 0, 0, 1, 0);
        // R8: younger mapping survives
        idle("R8", 1, 1);
        step("R7", 0, 0, 1, 1, 0, 0, 0, 1, 0);
        step("R6", 0, 0, 1, 1, 1, 1, 16'h2222, 0, 0);
        step("R7", 0, 0, 1, 1, 0, 0, 0, 1, 0);
        // R3: unmapped, architectural value
        idle("R3", 1, 0);
        // R10: fill all buffers then stall
        for (int k = 0; k < 6; k++) step("R10", 1, k, 1, k, 0, 0, 0, 0, 0);
        idle("R10", 2, 3);
        // R5: rename value preferred over architectural
        step("R5", 0, 0, 1, 1, 1, 0, 16'h3333, 0, 0);
        idle("R5", 0, 1);
        // R11: flush ignores everything else, then releases
        step("R11", 1, 4, 0, 1, 1, 1, 16'h4444, 1, 1);
        idle("R11", 1, 0);
        idle("R11", 2, 3);
        // randomized phase
        for (int c = 0; c < 4000; c++) begin
            bit dv, wv, cv, fl;
            int rd, rs1, rs2, wt, wd;
            dv  = ($urandom % 10) < 6;
            rd  = $urandom % 4;
            rs1 = (($urandom % 4) == 0) ? int'($urandom % NA) : int'($urandom % 4);
            rs2 = $urandom % 4;
            wv  = ($urandom % 2) == 1;
            wt  = $urandom % NR;
            wd  = $urandom % 65536;
            cv  = ($urandom % 10) < 6;
            fl  = ($urandom % 60) == 0;
            step("RND", dv, rd, rs1, rs2, wv, wt, wd, cv, fl);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule